// File: doc/BRIEF.md
# Banked Internal Data Memory with Hardware Stack

This block holds a 256-byte on-chip data store and resolves each access a processor core makes into it. On every clock the core presents one request: an access kind, an address or register number, optional write data, and the two bank-select bits of its status word. The block turns that request into a store location, a forward to the special-register port, or a stack-pointer update.

Working registers R0 to R7 live in four eight-byte banks at the bottom of the store. The current bank comes from the two select bits. Direct addresses in the lower half reach the store. Direct addresses in the upper half go out on a separate special-register port, except one address that reaches the block's own stack pointer. Indirect accesses use R0 or R1 of the current bank as a pointer, so they reach all 256 bytes, including the upper half that direct mode cannot reach. Push and pop move bytes through the store at the stack pointer.

Every access takes one clock. Read data is registered and appears one cycle after the request, and the busy output is held low.

Top module: `bankmem_top`

## Requirements
- R1: Register kind (req_kind=0) with register number n in req_addr[2:0] accesses store byte {3'b000, bank_sel[1:0], n[2:0]}.
- R2: Direct kind (req_kind=1) with req_addr[7]=0 reads or writes store byte req_addr.
- R3: Direct kind with req_addr[7]=1 and req_addr different from SP_ADDR (default 0x81) leaves the store untouched. In the same cycle it drives sfr_en=1, sfr_addr=req_addr, sfr_wr=req_wr and sfr_wdata=req_wdata. A read returns sfr_rdata on rd_data one cycle later.
- R4: Indirect kind (req_kind=2) uses R0 (req_addr[0]=0) or R1 (req_addr[0]=1) of the current bank as an 8-bit pointer and reaches any of the 256 store bytes. It never asserts sfr_en.
- R5: After reset the stack pointer (sp_out) is 0x07 and rd_valid is 0.
- R6: Push kind (req_kind=3) first adds one to the stack pointer, then writes req_wdata at the new stack-pointer value.
- R7: Pop kind (req_kind=4) returns the byte at the current stack pointer on rd_data and then subtracts one from the stack pointer.
- R8: The stack pointer wraps modulo 256 in both directions. A push from 0xFF writes byte 0x00, and a pop from 0x00 leaves 0xFF.
- R9: A direct access at SP_ADDR reads or writes the stack pointer itself.
- R10: A read (pop, or a register, direct or indirect kind with req_wr=0) places its data on rd_data with rd_valid=1 in the cycle after the request. busy is always 0.
- R11: With req_valid=0, or with req_kind in 5 to 7, nothing changes: the store, the stack pointer and the special-register strobes are left alone, and rd_valid is 0 on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Request present this cycle |
| req_kind | input | 3 | 0 register, 1 direct, 2 indirect, 3 push, 4 pop |
| req_wr | input | 1 | Write for register, direct and indirect kinds |
| req_addr | input | 8 | Direct address, register number [2:0], or pointer select [0] |
| req_wdata | input | 8 | Write or push data |
| bank_sel | input | 2 | Current register bank |
| rd_data | output | 8 | Registered read result |
| rd_valid | output | 1 | rd_data holds the result of the previous cycle's read |
| busy | output | 1 | Always 0 |
| sp_out | output | 8 | Current stack pointer |
| sfr_en | output | 1 | Special-register access strobe |
| sfr_wr | output | 1 | Special-register write |
| sfr_addr | output | 8 | Special-register address |
| sfr_wdata | output | 8 | Special-register write data |
| sfr_rdata | input | 8 | Special-register read data, sampled in the request cycle |

## Verification
If the stack pointer went wrong, sp_out would show it on the very next cycle. A pop would then return the wrong byte one cycle later. If bank relocation were wrong, a register write would land where a later direct read of the expected address does not find it, so the error shows on the first read-back. If the overlay decode were wrong, a direct upper read would return store contents instead of the special-register value, or an indirect upper read would strobe sfr_en in the same cycle. Each of these shows at the ports within one or two cycles of the faulty access.

// File: rtl/bankmem_pkg.sv
package bankmem_pkg;
  localparam int DW = 8;
  localparam int AW = 8;
  localparam int BW = 2;
  localparam int NW = 3;

  typedef enum logic [2:0] {
    AM_REG  = 3'd0,
    AM_DIR  = 3'd1,
    AM_IND  = 3'd2,
    AM_PUSH = 3'd3,
    AM_POP  = 3'd4
  } am_e;

  // bank relocation of a working register number
  function automatic logic [AW-1:0] bank_addr(input logic [BW-1:0] b,
                                              input logic [NW-1:0] n);
    return {{(AW-BW-NW){1'b0}}, b, n};
  endfunction

  // stack pointer arithmetic, modulo 2**AW
  function automatic logic [AW-1:0] sp_up(input logic [AW-1:0] s);
    return s + 1'b1;
  endfunction

  function automatic logic [AW-1:0] sp_down(input logic [AW-1:0] s);
    return s - 1'b1;
  endfunction
endpackage

// File: rtl/bankmem_store.sv
module bankmem_store #(
  parameter int DW = 8,
  parameter int AW = 8
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata,
  input  logic [AW-1:0] paddr,
  output logic [DW-1:0] pdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] cells [DEPTH];

  always_ff @(posedge clk) begin
    if (we) cells[waddr] <= wdata;
  end

  // data port and pointer port, both combinational
  assign rdata = cells[raddr];
  assign pdata = cells[paddr];
endmodule

// File: rtl/bankmem_sp.sv
module bankmem_sp
  import bankmem_pkg::*;
#(
  parameter int          AW     = 8,
  parameter logic [AW-1:0] SP_RST = 8'h07
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [AW-1:0] load_val,
  input  logic          inc,
  input  logic          dec,
  output logic [AW-1:0] sp
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    sp <= SP_RST;
    else if (load) sp <= load_val;
    else if (inc)  sp <= sp_up(sp);
    else if (dec)  sp <= sp_down(sp);
  end

  // R6: push raises the pointer by one
  a_r6_push_preinc: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !load) |=> (sp == $past(sp) + 8'd1));

  // R7: pop lowers the pointer by one
  a_r7_pop_postdec: assert property (@(posedge clk) disable iff (!rst_n)
    (dec && !inc && !load) |=> (sp == $past(sp) - 8'd1));
endmodule

// File: rtl/bankmem_route.sv
module bankmem_route
  import bankmem_pkg::*;
#(
  parameter int            AW      = 8,
  parameter int            BW      = 2,
  parameter logic [AW-1:0] SP_ADDR = 8'h81
) (
  input  logic          valid,
  input  logic [2:0]    kind,
  input  logic          wr,
  input  logic [AW-1:0] addr,
  input  logic [BW-1:0] bank,
  input  logic [AW-1:0] ptr,
  input  logic [AW-1:0] sp,
  output logic [AW-1:0] ptr_addr,
  output logic [AW-1:0] ram_addr,
  output logic          ram_we,
  output logic          ram_rd,
  output logic          sfr_hit,
  output logic          sp_hit,
  output logic          push_go,
  output logic          pop_go
);
  always_comb begin
    ptr_addr = bank_addr(bank, {2'b00, addr[0]});
    ram_addr = addr;
    ram_we   = 1'b0;
    ram_rd   = 1'b0;
    sfr_hit  = 1'b0;
    sp_hit   = 1'b0;
    push_go  = 1'b0;
    pop_go   = 1'b0;
    if (valid) begin
      case (kind)
        AM_REG: begin
          ram_addr = bank_addr(bank, addr[2:0]);
          ram_we   = wr;
          ram_rd   = !wr;
        end
        AM_DIR: begin
          if (!addr[AW-1]) begin
            ram_we = wr;
            ram_rd = !wr;
          end else if (addr == SP_ADDR) begin
            sp_hit = 1'b1;
          end else begin
            sfr_hit = 1'b1;
          end
        end
        AM_IND: begin
          ram_addr = ptr;
          ram_we   = wr;
          ram_rd   = !wr;
        end
        AM_PUSH: begin
          ram_addr = sp_up(sp);
          ram_we   = 1'b1;
          push_go  = 1'b1;
        end
        AM_POP: begin
          ram_addr = sp;
          ram_rd   = 1'b1;
          pop_go   = 1'b1;
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/bankmem_top.sv
module bankmem_top
  import bankmem_pkg::*;
#(
  parameter int            DW      = 8,
  parameter int            AW      = 8,
  parameter int            BW      = 2,
  parameter logic [AW-1:0] SP_ADDR = 8'h81,
  parameter logic [AW-1:0] SP_RST  = 8'h07
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic [2:0]    req_kind,
  input  logic          req_wr,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic [BW-1:0] bank_sel,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          busy,
  output logic [AW-1:0] sp_out,
  output logic          sfr_en,
  output logic          sfr_wr,
  output logic [AW-1:0] sfr_addr,
  output logic [DW-1:0] sfr_wdata,
  input  logic [DW-1:0] sfr_rdata
);
  logic [AW-1:0] ptr_addr, ram_addr, sp_q;
  logic [DW-1:0] ram_q, ptr_q, wr_byte;
  logic          ram_we, ram_rd, sfr_hit, sp_hit, push_go, pop_go;
  logic          sp_load;

  bankmem_route #(.AW(AW), .BW(BW), .SP_ADDR(SP_ADDR)) u_route (
    .valid(req_valid), .kind(req_kind), .wr(req_wr), .addr(req_addr),
    .bank(bank_sel), .ptr(ptr_q), .sp(sp_q), .ptr_addr(ptr_addr),
    .ram_addr(ram_addr), .ram_we(ram_we), .ram_rd(ram_rd),
    .sfr_hit(sfr_hit), .sp_hit(sp_hit), .push_go(push_go), .pop_go(pop_go)
  );

  assign wr_byte = req_wdata;

  bankmem_store #(.DW(DW), .AW(AW)) u_store (
    .clk(clk), .we(ram_we), .waddr(ram_addr), .wdata(wr_byte),
    .raddr(ram_addr), .rdata(ram_q), .paddr(ptr_addr), .pdata(ptr_q)
  );

  assign sp_load = sp_hit && req_wr;

  bankmem_sp #(.AW(AW), .SP_RST(SP_RST)) u_sp (
    .clk(clk), .rst_n(rst_n), .load(sp_load), .load_val(req_wdata),
    .inc(push_go), .dec(pop_go), .sp(sp_q)
  );

  assign sp_out    = sp_q;
  assign busy      = 1'b0;
  assign sfr_en    = sfr_hit;
  assign sfr_wr    = sfr_hit && req_wr;
  assign sfr_addr  = req_addr;
  assign sfr_wdata = req_wdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= ram_rd || ((sfr_hit || sp_hit) && !req_wr);
      if (ram_rd)                  rd_data <= ram_q;
      else if (sfr_hit && !req_wr) rd_data <= sfr_rdata;
      else if (sp_hit && !req_wr)  rd_data <= sp_q;
    end
  end

  // R3: strobe only for upper direct addresses
  a_r3_sfr_upper: assert property (@(posedge clk) disable iff (!rst_n)
    sfr_en |-> (sfr_addr[AW-1] && req_kind == AM_DIR));

  // R4: indirect never reaches the special-register port
  a_r4_ind_no_sfr: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == AM_IND) |-> !sfr_en);

  // R10: a pop is answered on the next cycle
  a_r10_pop_answers: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_kind == AM_POP) |=> rd_valid);

  // R11: an idle cycle keeps the pointer and produces no result
  a_r11_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> ($stable(sp_out) && !rd_valid));
endmodule

// File: tb/bankmem_top_bench.sv
module bankmem_top_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       req_valid = 1'b0;
  logic [2:0] req_kind = 3'd0;
  logic       req_wr = 1'b0;
  logic [7:0] req_addr = 8'h00;
  logic [7:0] req_wdata = 8'h00;
  logic [1:0] bank_sel = 2'd0;
  logic [7:0] rd_data, sp_out, sfr_addr, sfr_wdata, sfr_rdata;
  logic       rd_valid, busy, sfr_en, sfr_wr;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  assign sfr_rdata = ~sfr_addr;

  bankmem_top u_bankmem_top (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_kind(req_kind),
    .req_wr(req_wr), .req_addr(req_addr), .req_wdata(req_wdata),
    .bank_sel(bank_sel), .rd_data(rd_data), .rd_valid(rd_valid), .busy(busy),
    .sp_out(sp_out), .sfr_en(sfr_en), .sfr_wr(sfr_wr), .sfr_addr(sfr_addr),
    .sfr_wdata(sfr_wdata), .sfr_rdata(sfr_rdata)
  );

  task automatic check(input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // drive at a falling edge, return at the next falling edge
  task automatic op(input logic [2:0] k, input logic w, input logic [7:0] a,
                    input logic [1:0] b, input logic [7:0] d);
    req_valid = 1'b1; req_kind = k; req_wr = w; req_addr = a;
    bank_sel = b; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  // {rq, kind, wr, addr, bank, wdata, chk, exp, sp}
  localparam int NV = 21;
  localparam logic [42:0] VEC [NV] = '{
    {4'd1,  3'd0, 1'b1, 8'h00, 2'd0, 8'h11, 1'b0, 8'h00, 8'h07}, // R1 bank0 R0
    {4'd1,  3'd0, 1'b1, 8'h00, 2'd2, 8'h22, 1'b0, 8'h00, 8'h07}, // R1 bank2 R0
    {4'd2,  3'd1, 1'b0, 8'h00, 2'd0, 8'h00, 1'b1, 8'h11, 8'h07}, // R2
    {4'd2,  3'd1, 1'b0, 8'h10, 2'd0, 8'h00, 1'b1, 8'h22, 8'h07}, // R2
    {4'd1,  3'd0, 1'b1, 8'h01, 2'd3, 8'h90, 1'b0, 8'h00, 8'h07}, // R1 bank3 R1
    {4'd4,  3'd2, 1'b1, 8'h01, 2'd3, 8'hC3, 1'b0, 8'h00, 8'h07}, // R4 upper write
    {4'd3,  3'd1, 1'b0, 8'h90, 2'd0, 8'h00, 1'b1, 8'h6F, 8'h07}, // R3 sfr read
    {4'd4,  3'd2, 1'b0, 8'h01, 2'd3, 8'h00, 1'b1, 8'hC3, 8'h07}, // R4 upper read
    {4'd1,  3'd1, 1'b0, 8'h19, 2'd0, 8'h00, 1'b1, 8'h90, 8'h07}, // R1 placement
    {4'd6,  3'd3, 1'b0, 8'h00, 2'd0, 8'hA1, 1'b0, 8'h00, 8'h08}, // R6
    {4'd6,  3'd3, 1'b0, 8'h00, 2'd0, 8'hB2, 1'b0, 8'h00, 8'h09}, // R6
    {4'd6,  3'd1, 1'b0, 8'h08, 2'd0, 8'h00, 1'b1, 8'hA1, 8'h09}, // R6 first slot 08
    {4'd7,  3'd4, 1'b0, 8'h00, 2'd0, 8'h00, 1'b1, 8'hB2, 8'h08}, // R7
    {4'd7,  3'd4, 1'b0, 8'h00, 2'd0, 8'h00, 1'b1, 8'hA1, 8'h07}, // R7
    {4'd9,  3'd1, 1'b0, 8'h81, 2'd0, 8'h00, 1'b1, 8'h07, 8'h07}, // R9 read
    {4'd9,  3'd1, 1'b1, 8'h81, 2'd0, 8'h09, 1'b0, 8'h00, 8'h09}, // R9 write
    {4'd6,  3'd3, 1'b0, 8'h00, 2'd0, 8'h23, 1'b0, 8'h00, 8'h0A}, // R6
    {4'd6,  3'd3, 1'b0, 8'h00, 2'd0, 8'h01, 1'b0, 8'h00, 8'h0B}, // R6
    {4'd6,  3'd1, 1'b0, 8'h0A, 2'd0, 8'h00, 1'b1, 8'h23, 8'h0B}, // R6
    {4'd6,  3'd1, 1'b0, 8'h0B, 2'd0, 8'h00, 1'b1, 8'h01, 8'h0B}, // R6
    {4'd10, 3'd0, 1'b0, 8'h00, 2'd0, 8'h00, 1'b1, 8'h11, 8'h0B}  // R10 register read
  };

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R5 reset state, R10 busy low
    check("R5 sp reset", sp_out, 8'h07);
    check("R5 rd_valid reset", {7'd0, rd_valid}, 8'h00);
    check("R10 busy", {7'd0, busy}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      logic [42:0] v;
      string tag;
      v = VEC[i];
      tag = $sformatf("R%0d vec%0d", v[42:39], i);
      op(v[38:36], v[35], v[34:27], v[26:25], v[24:17]);
      if (v[16]) begin
        check({tag, " data"}, rd_data, v[15:8]);
        check({tag, " valid"}, {7'd0, rd_valid}, 8'h01);
      end
      check({tag, " sp"}, sp_out, v[7:0]);
    end

    // R3: upper direct write goes out on the port, store byte kept (R4 path)
    op(3'd0, 1'b1, 8'h00, 2'd1, 8'hA0);        // bank1 R0 = A0
    op(3'd2, 1'b1, 8'h00, 2'd1, 8'h77);        // store[A0] = 77
    req_valid = 1'b1; req_kind = 3'd1; req_wr = 1'b1;
    req_addr = 8'hA0; req_wdata = 8'h3C; bank_sel = 2'd0;
    #1;
    check("R3 sfr_en", {7'd0, sfr_en}, 8'h01);
    check("R3 sfr_wr", {7'd0, sfr_wr}, 8'h01);
    check("R3 sfr_addr", sfr_addr, 8'hA0);
    check("R3 sfr_wdata", sfr_wdata, 8'h3C);
    @(negedge clk);
    req_valid = 1'b0;
    op(3'd2, 1'b0, 8'h00, 2'd1, 8'h00);
    check("R3 store untouched", rd_data, 8'h77);
    // R4: indirect upper access strobes nothing
    req_valid = 1'b1; req_kind = 3'd2; req_wr = 1'b0;
    req_addr = 8'h00; bank_sel = 2'd1;
    #1;
    check("R4 no sfr_en", {7'd0, sfr_en}, 8'h00);
    @(negedge clk);
    req_valid = 1'b0;

    // R8: wrap in both directions
    op(3'd1, 1'b1, 8'h81, 2'd0, 8'hFF);
    check("R8 sp load", sp_out, 8'hFF);
    op(3'd3, 1'b0, 8'h00, 2'd0, 8'h5E);
    check("R8 push wrap sp", sp_out, 8'h00);
    op(3'd1, 1'b0, 8'h00, 2'd0, 8'h00);
    check("R8 push wrap byte", rd_data, 8'h5E);
    op(3'd4, 1'b0, 8'h00, 2'd0, 8'h00);
    check("R8 pop data", rd_data, 8'h5E);
    check("R8 pop wrap sp", sp_out, 8'hFF);

    // R11: idle request and unused kinds
    req_valid = 1'b0; req_kind = 3'd3; req_wdata = 8'hEE;
    @(negedge clk);
    check("R11 idle sp", sp_out, 8'hFF);
    check("R11 idle rd_valid", {7'd0, rd_valid}, 8'h00);
    req_valid = 1'b1; req_kind = 3'd7; req_wr = 1'b1;
    req_addr = 8'h90; req_wdata = 8'hEE;
    #1;
    check("R11 kind7 sfr_en", {7'd0, sfr_en}, 8'h00);
    @(negedge clk);
    req_valid = 1'b0;
    check("R11 kind7 sp", sp_out, 8'hFF);
    check("R11 kind7 rd_valid", {7'd0, rd_valid}, 8'h00);
    op(3'd1, 1'b0, 8'h00, 2'd0, 8'h00);
    check("R11 store kept", rd_data, 8'h5E);

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule